// File: doc/BRIEF.md
# Three-Phase Bridge Fault Diagnosis Sequencer

This block runs the diagnosis flow of a three-phase motor bridge. A start request first closes the off-state sense switches with the bridge held off. The block waits a programmable settling time and then samples the per-phase high and low comparator flags. If that check is clean, the block opens the switches, enables the on-state monitor and enables the bridge.

When any on-state flag rises while the bridge runs, the block drops the bridge and records which flags were raised. It then closes the sense switches again for a second off-state check. The block only decides the root cause after that second check. It does so by weighing the recorded on-state flags against the off-state pattern.

The verdict is stored as sticky bits in a 23-bit fault vector that a host reads over a register interface. A read-and-erase strobe clears the vector. No new start is accepted while any bit is still set.

Top module: `bridge_diag_seq`

## Requirements
- R1: While reset is asserted and after it is released, `off_sw_o`, `on_mon_o`, `bridge_en_o` and `fault_o` are all zero.
- R2: A start request taken in idle with a zero fault vector closes all three sense switches from the next cycle. If the sampled off-state flags are all zero, the block then opens the switches and raises `bridge_en_o` and `on_mon_o` together.
- R3: A non-clean off-state pattern found after a start leaves the bridge off and returns the block to idle, setting one bit. The off-state flag vectors are indexed bit 0 = U, bit 1 = V, bit 2 = W.
  - high flags 111 with low flags 000 set bit 3.
  - low flags 111 with high flags 000 set bit 4.
  - low 001 / high 110 sets bit 0 (open U).
  - low 101 / high 010 sets bit 1 (open V).
  - low 100 / high 011 sets bit 2 (open W).
  - The open-phase bits are also set when those patterns appear in the second check.
- R4: An on-state flag seen while the bridge is enabled drops `bridge_en_o` and `on_mon_o` and closes all sense switches on the next cycle.
- R5: A lone on-state battery short on phase p, followed by an all-high second check, sets bit 5+p. A lone on-state ground short on phase p, followed by an all-low second check, sets bit 8+p.
- R6: With a clean second check, two cases set a load-short bit.
  - A lone on-state short on phase p, of either kind, sets bit 11+p.
  - One battery short and one ground short on two different phases set bit 14 for the U/V pair, bit 15 for U/W and bit 16 for V/W.
- R7: A lone on-state weak-short flag followed by an all-high second check sets bit 17.
- R8: Any other outcome sets bit 18. This covers an off-state pattern after a start that fits no rule in R3, and any on-state/off-state combination in the second check that fits no rule in R5 to R7.
- R9: A start request is ignored while the fault vector is non-zero. The switches and the bridge stay off.
- R10: The clear strobe zeroes the whole vector in one cycle. A bit set in the same cycle as the clear stays set.
- R11: With settle value S, the off-state flags are sampled only in the (S+1)th cycle after the switches close. Values shown earlier have no effect.
- R12: Bits 22 to 19 of `fault_o` always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request for the bridge |
| settle_i | input | SETTLE_W | Settling cycles before the off-state sample |
| off_scb_i | input | 3 | Off-state high-side comparator flags, bit0=U |
| off_scg_i | input | 3 | Off-state low-side comparator flags, bit0=U |
| on_scb_i | input | 3 | On-state battery-short flags per phase |
| on_scg_i | input | 3 | On-state ground-short flags per phase |
| on_wsc_i | input | 1 | On-state weak-short flag |
| clr_i | input | 1 | Host read-and-erase strobe |
| off_sw_o | output | 3 | Off-state sense switch enables |
| on_mon_o | output | 1 | On-state monitor enable |
| bridge_en_o | output | 1 | Bridge enable |
| fault_o | output | 23 | Latched fault vector |

## Verification
The hardest situation to reach is a clear strobe that lands in the very cycle the second check writes its verdict. A new bit can only appear after a full start, settle and check sequence. The bench therefore counts settle cycles from the start strobe and raises the clear exactly on the sampling edge.

Equally delicate is proving that comparator values shown before the sample point are ignored. The stimulus presents an all-high pattern during settling and turns it clean one cycle before sampling. The bridge must then come up with no fault recorded.

// File: rtl/bdiag_pkg.sv
package bdiag_pkg;
    localparam int NPH     = 3;
    localparam int FAULT_W = 23;

    // fault vector bit positions
    localparam int B_OPEN  = 0;   // 0..2 open phase
    localparam int B_OFFHI = 3;   // off-state all high
    localparam int B_OFFLO = 4;   // off-state all low
    localparam int B_BAT   = 5;   // 5..7 phase short to battery
    localparam int B_GND   = 8;   // 8..10 phase short to ground
    localparam int B_LOAD  = 11;  // 11..13 load short at phase
    localparam int B_PAIR  = 14;  // 14..16 load short between phases
    localparam int B_WEAK  = 17;  // weak short to battery
    localparam int B_UNCL  = 18;  // unclassified
    localparam int B_USED  = 19;  // bits at and above are reserved

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_OFFCHK,
        ST_RUN,
        ST_RECHK
    } seq_st_e;

    typedef enum logic [2:0] {
        OC_CLEAN,
        OC_ALLHI,
        OC_ALLLO,
        OC_OPEN_U,
        OC_OPEN_V,
        OC_OPEN_W,
        OC_OTHER
    } off_cls_e;
endpackage

// File: rtl/bdiag_settle_timer.sv
module bdiag_settle_timer #(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear_i,
    input  logic [SETTLE_W-1:0] limit_i,
    output logic                done_o
);
    logic [SETTLE_W-1:0] cnt_d, cnt_q;

    assign done_o = (cnt_q == limit_i);

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (!done_o) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/bdiag_off_classify.sv
module bdiag_off_classify
    import bdiag_pkg::*;
(
    input  logic [NPH-1:0] hi_i,
    input  logic [NPH-1:0] lo_i,
    output off_cls_e       cls_o
);
    localparam logic [NPH-1:0] ALL = '1;

    always_comb begin
        cls_o = OC_OTHER;
        if (hi_i == '0 && lo_i == '0) begin
            cls_o = OC_CLEAN;
        end else if (hi_i == ALL && lo_i == '0) begin
            cls_o = OC_ALLHI;
        end else if (lo_i == ALL && hi_i == '0) begin
            cls_o = OC_ALLLO;
        end else if (lo_i == 3'b001 && hi_i == 3'b110) begin
            cls_o = OC_OPEN_U;
        end else if (lo_i == 3'b101 && hi_i == 3'b010) begin
            cls_o = OC_OPEN_V;
        end else if (lo_i == 3'b100 && hi_i == 3'b011) begin
            cls_o = OC_OPEN_W;
        end
    end
endmodule

// File: rtl/bdiag_fault_map.sv
module bdiag_fault_map
    import bdiag_pkg::*;
(
    input  off_cls_e             cls_i,
    input  logic [NPH-1:0]       cap_bat_i,
    input  logic [NPH-1:0]       cap_gnd_i,
    input  logic                 cap_weak_i,
    output logic [FAULT_W-1:0]   start_set_o,
    output logic [FAULT_W-1:0]   final_set_o
);
    logic lone_bat, lone_gnd, lone_weak, is_pair;
    logic [NPH-1:0] pair_mask;

    assign lone_bat  = ($countones(cap_bat_i) == 1) && (cap_gnd_i == '0) && !cap_weak_i;
    assign lone_gnd  = ($countones(cap_gnd_i) == 1) && (cap_bat_i == '0) && !cap_weak_i;
    assign lone_weak = cap_weak_i && (cap_bat_i == '0) && (cap_gnd_i == '0);
    assign is_pair   = ($countones(cap_bat_i) == 1) && ($countones(cap_gnd_i) == 1)
                       && ((cap_bat_i & cap_gnd_i) == '0) && !cap_weak_i;
    assign pair_mask = cap_bat_i | cap_gnd_i;

    // verdict for the check that follows a start request
    always_comb begin
        start_set_o = '0;
        case (cls_i)
            OC_ALLHI:  start_set_o[B_OFFHI]    = 1'b1;
            OC_ALLLO:  start_set_o[B_OFFLO]    = 1'b1;
            OC_OPEN_U: start_set_o[B_OPEN + 0] = 1'b1;
            OC_OPEN_V: start_set_o[B_OPEN + 1] = 1'b1;
            OC_OPEN_W: start_set_o[B_OPEN + 2] = 1'b1;
            OC_OTHER:  start_set_o[B_UNCL]     = 1'b1;
            default:   start_set_o             = '0;
        endcase
    end

    // verdict for the check that follows an on-state fault
    always_comb begin
        final_set_o = '0;
        case (cls_i)
            OC_OPEN_U: final_set_o[B_OPEN + 0] = 1'b1;
            OC_OPEN_V: final_set_o[B_OPEN + 1] = 1'b1;
            OC_OPEN_W: final_set_o[B_OPEN + 2] = 1'b1;
            default: begin
                for (int p = 0; p < NPH; p++) begin
                    if (lone_bat && cap_bat_i[p]) begin
                        if (cls_i == OC_ALLHI)      final_set_o[B_BAT + p]  = 1'b1;
                        else if (cls_i == OC_CLEAN) final_set_o[B_LOAD + p] = 1'b1;
                    end
                    if (lone_gnd && cap_gnd_i[p]) begin
                        if (cls_i == OC_ALLLO)      final_set_o[B_GND + p]  = 1'b1;
                        else if (cls_i == OC_CLEAN) final_set_o[B_LOAD + p] = 1'b1;
                    end
                end
                if (is_pair && cls_i == OC_CLEAN) begin
                    case (pair_mask)
                        3'b011:  final_set_o[B_PAIR + 0] = 1'b1;
                        3'b101:  final_set_o[B_PAIR + 1] = 1'b1;
                        3'b110:  final_set_o[B_PAIR + 2] = 1'b1;
                        default: final_set_o[B_UNCL]     = 1'b1;
                    endcase
                end
                if (lone_weak && cls_i == OC_ALLHI) begin
                    final_set_o[B_WEAK] = 1'b1;
                end
                if (final_set_o == '0) begin
                    final_set_o[B_UNCL] = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/bridge_diag_seq.sv
module bridge_diag_seq
    import bdiag_pkg::*;
#(
    parameter int SETTLE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [SETTLE_W-1:0] settle_i,
    input  logic [2:0]          off_scb_i,
    input  logic [2:0]          off_scg_i,
    input  logic [2:0]          on_scb_i,
    input  logic [2:0]          on_scg_i,
    input  logic                on_wsc_i,
    input  logic                clr_i,
    output logic [2:0]          off_sw_o,
    output logic                on_mon_o,
    output logic                bridge_en_o,
    output logic [22:0]         fault_o
);
    typedef struct packed {
        seq_st_e              st;
        logic [NPH-1:0]       cap_bat;
        logic [NPH-1:0]       cap_gnd;
        logic                 cap_weak;
        logic [FAULT_W-1:0]   flt;
    } seq_regs_t;

    seq_regs_t d, q;

    logic               tmr_clear, tmr_done, on_hit, in_check;
    off_cls_e           cls;
    logic [FAULT_W-1:0] start_set, final_set, set_now;

    assign in_check  = (q.st == ST_OFFCHK) || (q.st == ST_RECHK);
    assign tmr_clear = !in_check;
    assign on_hit    = (|on_scb_i) || (|on_scg_i) || on_wsc_i;

    bdiag_settle_timer #(.SETTLE_W(SETTLE_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clear),
        .limit_i (settle_i),
        .done_o  (tmr_done)
    );

    bdiag_off_classify u_cls (
        .hi_i  (off_scb_i),
        .lo_i  (off_scg_i),
        .cls_o (cls)
    );

    bdiag_fault_map u_map (
        .cls_i       (cls),
        .cap_bat_i   (q.cap_bat),
        .cap_gnd_i   (q.cap_gnd),
        .cap_weak_i  (q.cap_weak),
        .start_set_o (start_set),
        .final_set_o (final_set)
    );

    always_comb begin
        d       = q;
        set_now = '0;
        case (q.st)
            ST_IDLE: begin
                if (start_i && q.flt == '0) begin
                    d.st = ST_OFFCHK;
                end
            end
            ST_OFFCHK: begin
                if (tmr_done) begin
                    if (cls == OC_CLEAN) begin
                        d.st = ST_RUN;
                    end else begin
                        set_now = start_set;
                        d.st    = ST_IDLE;
                    end
                end
            end
            ST_RUN: begin
                if (on_hit) begin
                    d.cap_bat  = on_scb_i;
                    d.cap_gnd  = on_scg_i;
                    d.cap_weak = on_wsc_i;
                    d.st       = ST_RECHK;
                end
            end
            ST_RECHK: begin
                if (tmr_done) begin
                    set_now = final_set;
                    d.st    = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        d.flt = (clr_i ? '0 : q.flt) | set_now;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cap_bat: '0, cap_gnd: '0, cap_weak: 1'b0, flt: '0};
        end else begin
            q <= d;
        end
    end

    assign off_sw_o    = {NPH{in_check}};
    assign bridge_en_o = (q.st == ST_RUN);
    assign on_mon_o    = (q.st == ST_RUN);
    assign fault_o     = q.flt;
endmodule

// File: rtl/bdiag_chk.sv
module bdiag_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [2:0]  on_scb_i,
    input logic [2:0]  on_scg_i,
    input logic        on_wsc_i,
    input logic        clr_i,
    input logic [2:0]  off_sw_o,
    input logic        bridge_en_o,
    input logic [22:0] fault_o
);
    AST_ENABLE_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bridge_en_o) |-> ($past(off_sw_o) == 3'b111 && $past(fault_o) == '0)); // R2

    AST_DROP_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (bridge_en_o && ((|on_scb_i) || (|on_scg_i) || on_wsc_i))
        |=> (!bridge_en_o && off_sw_o == 3'b111)); // R4

    AST_SWITCH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_en_o |-> off_sw_o == 3'b000); // R4

    AST_START_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(off_sw_o[0]) && !$past(bridge_en_o)) |-> ($past(start_i) && $past(fault_o) == '0)); // R9

    AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(fault_o) & ~fault_o)) |-> $past(clr_i)); // R10

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o[22:19] == 4'b0000); // R12
endmodule

bind bridge_diag_seq bdiag_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .on_scb_i    (on_scb_i),
    .on_scg_i    (on_scg_i),
    .on_wsc_i    (on_wsc_i),
    .clr_i       (clr_i),
    .off_sw_o    (off_sw_o),
    .bridge_en_o (bridge_en_o),
    .fault_o     (fault_o)
);

// File: tb/sim_bridge_diag_seq.sv
`timescale 1ns/1ps
module sim_bridge_diag_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  settle = 8'd3;
    logic [2:0]  offb = '0, offg = '0, onb = '0, ong = '0;
    logic        onw = 1'b0, clr = 1'b0;
    logic [2:0]  off_sw;
    logic        on_mon, bridge_en;
    logic [22:0] fault;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bridge_diag_seq #(.SETTLE_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .settle_i(settle),
        .off_scb_i(offb), .off_scg_i(offg), .on_scb_i(onb), .on_scg_i(ong),
        .on_wsc_i(onw), .clr_i(clr), .off_sw_o(off_sw), .on_mon_o(on_mon),
        .bridge_en_o(bridge_en), .fault_o(fault)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // 0 idle, 1 first check, 2 running, 3 second check
    int          m_mode = 0;
    int          m_wait = 0;
    logic [2:0]  m_b = '0, m_g = '0;
    logic        m_w = 1'b0;
    logic [22:0] m_flt = '0;

    function automatic int off_kind(input logic [2:0] b, input logic [2:0] g);
        if (b == 0 && g == 0) return 0;
        if (b == 7 && g == 0) return 1;
        if (g == 7 && b == 0) return 2;
        if (g == 3'b001 && b == 3'b110) return 3;
        if (g == 3'b101 && b == 3'b010) return 4;
        if (g == 3'b100 && b == 3'b011) return 5;
        return 6;
    endfunction

    function automatic int first_bit(input int k);
        case (k)
            1: return 3;
            2: return 4;
            3: return 0;
            4: return 1;
            5: return 2;
            default: return 18;
        endcase
    endfunction

    function automatic int phase_of(input logic [2:0] v);
        return v[0] ? 0 : (v[1] ? 1 : 2);
    endfunction

    function automatic int second_bit(input int k, input logic [2:0] b, input logic [2:0] g, input logic w);
        int nb, ng;
        nb = $countones(b);
        ng = $countones(g);
        if (k >= 3 && k <= 5) return k - 3;
        if (w) return (nb == 0 && ng == 0 && k == 1) ? 17 : 18;
        if (nb == 1 && ng == 0) return k == 1 ? 5 + phase_of(b) : (k == 0 ? 11 + phase_of(b) : 18);
        if (ng == 1 && nb == 0) return k == 2 ? 8 + phase_of(g) : (k == 0 ? 11 + phase_of(g) : 18);
        if (nb == 1 && ng == 1 && (b & g) == 0 && k == 0) begin
            if ((b | g) == 3'b011) return 14;
            if ((b | g) == 3'b101) return 15;
            return 16;
        end
        return 18;
    endfunction

    always @(posedge clk) begin
        logic [22:0] add;
        add = '0;
        if (!rst_n) begin
            m_mode = 0; m_wait = 0; m_b = '0; m_g = '0; m_w = 0; m_flt = '0;
        end else begin
            case (m_mode)
                0: if (start && m_flt == 0) begin m_mode = 1; m_wait = 0; end
                1, 3: begin
                    if (m_wait == int'(settle)) begin
                        if (m_mode == 1) begin
                            if (off_kind(offb, offg) == 0) m_mode = 2;
                            else begin add[first_bit(off_kind(offb, offg))] = 1'b1; m_mode = 0; end
                        end else begin
                            add[second_bit(off_kind(offb, offg), m_b, m_g, m_w)] = 1'b1;
                            m_mode = 0;
                        end
                    end else m_wait++;
                end
                2: if (onb != 0 || ong != 0 || onw) begin
                    m_b = onb; m_g = ong; m_w = onw; m_mode = 3; m_wait = 0;
                end
                default: m_mode = 0;
            endcase
            m_flt = (clr ? 23'd0 : m_flt) | add;
        end
    end

    always @(negedge clk) begin
        logic [2:0] e_sw;
        e_sw = (m_mode == 1 || m_mode == 3) ? 3'b111 : 3'b000;
        chk(off_sw == e_sw, "R2 switch enables vs model", 32'(off_sw), 32'(e_sw));
        chk(bridge_en == (m_mode == 2), "R4 bridge enable vs model", 32'(bridge_en), 32'(m_mode == 2));
        chk(on_mon == (m_mode == 2), "R4 monitor enable vs model", 32'(on_mon), 32'(m_mode == 2));
        chk(fault == m_flt, "R5 fault vector vs model", 32'(fault), 32'(m_flt));
    end

    // ---------------- directed stimulus ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_clear();
        clr = 1; step(1); clr = 0;
    endtask

    task automatic start_case(input logic [2:0] b, input logic [2:0] g, input int exp_bit, input string tag);
        pulse_clear();
        offb = b; offg = g;
        start = 1; step(1); start = 0;
        step(int'(settle) + 1);
        chk(bridge_en == 0 && off_sw == 0, {tag, " bridge stays off"}, 32'(bridge_en), 0);
        chk(fault == (23'd1 << exp_bit), {tag, " fault bit"}, 32'(fault), 32'(23'd1 << exp_bit));
        offb = 0; offg = 0;
    endtask

    task automatic run_case(input logic [2:0] b, input logic [2:0] g, input logic w,
                            input logic [2:0] sb, input logic [2:0] sg, input int exp_bit, input string tag);
        pulse_clear();
        start = 1; step(1); start = 0;
        step(int'(settle) + 1);
        chk(bridge_en == 1 && on_mon == 1, "R2 bridge up after clean check", 32'(bridge_en), 1);
        onb = b; ong = g; onw = w; offb = sb; offg = sg;
        step(1);
        onb = 0; ong = 0; onw = 0;
        chk(bridge_en == 0 && off_sw == 3'b111, "R4 bridge off and switches closed", 32'({bridge_en, off_sw}), 32'h7);
        step(int'(settle) + 1);
        chk(fault == (23'd1 << exp_bit), {tag, " final verdict"}, 32'(fault), 32'(23'd1 << exp_bit));
        offb = 0; offg = 0;
    endtask

    initial begin
        step(3);
        chk(off_sw == 0 && on_mon == 0 && bridge_en == 0 && fault == 0, "R1 outputs in reset", 32'(fault), 0);
        rst_n = 1;
        step(1);
        chk(off_sw == 0 && bridge_en == 0 && fault == 0, "R1 outputs after reset", 32'(fault), 0);

        start_case(3'b111, 3'b000, 3,  "R3 all high");
        start_case(3'b000, 3'b111, 4,  "R3 all low");
        start_case(3'b110, 3'b001, 0,  "R3 open U");
        start_case(3'b010, 3'b101, 1,  "R3 open V");
        start_case(3'b011, 3'b100, 2,  "R3 open W");
        start_case(3'b001, 3'b000, 18, "R8 odd start pattern");

        // lockout: fault still set, start ignored
        start = 1; step(1); start = 0;
        step(int'(settle) + 2);
        chk(bridge_en == 0 && off_sw == 0, "R9 start refused with fault set", 32'({bridge_en, off_sw}), 0);
        chk(fault == (23'd1 << 18), "R9 fault unchanged", 32'(fault), 32'(23'd1 << 18));

        // settle window: early all-high pattern is ignored
        pulse_clear();
        offb = 3'b111;
        start = 1; step(1); start = 0;
        step(int'(settle));
        offb = 0;
        step(1);
        chk(bridge_en == 1 && fault == 0, "R11 early pattern ignored", 32'({bridge_en, fault}), 32'h1 << 23);
        onb = 3'b001; step(1); onb = 0;
        step(int'(settle) + 1);

        run_case(3'b001, 3'b000, 0, 3'b111, 3'b000, 5,  "R5 battery U");
        run_case(3'b100, 3'b000, 0, 3'b111, 3'b000, 7,  "R5 battery W");
        run_case(3'b000, 3'b010, 0, 3'b000, 3'b111, 9,  "R5 ground V");
        run_case(3'b100, 3'b000, 0, 3'b000, 3'b000, 13, "R6 load W");
        run_case(3'b000, 3'b001, 0, 3'b000, 3'b000, 11, "R6 load U via ground");
        run_case(3'b001, 3'b010, 0, 3'b000, 3'b000, 14, "R6 pair UV");
        run_case(3'b100, 3'b001, 0, 3'b000, 3'b000, 15, "R6 pair UW");
        run_case(3'b010, 3'b100, 0, 3'b000, 3'b000, 16, "R6 pair VW");
        run_case(3'b000, 3'b000, 1, 3'b111, 3'b000, 17, "R7 weak to battery");
        run_case(3'b000, 3'b000, 1, 3'b000, 3'b000, 18, "R8 weak with clean check");
        run_case(3'b001, 3'b000, 0, 3'b000, 3'b111, 18, "R8 battery with all low");
        run_case(3'b011, 3'b000, 0, 3'b000, 3'b000, 18, "R8 two battery flags");
        run_case(3'b001, 3'b000, 0, 3'b010, 3'b101, 1,  "R3 open V in second check");

        // clear on the very verdict edge
        pulse_clear();
        offb = 3'b111;
        start = 1; step(1); start = 0;
        step(int'(settle));
        clr = 1; step(1); clr = 0;
        step(1);
        chk(fault == (23'd1 << 3), "R10 same-cycle set survives clear", 32'(fault), 32'(23'd1 << 3));
        offb = 0;
        pulse_clear();
        step(1);
        chk(fault == 0, "R10 clear empties vector", 32'(fault), 0);

        settle = 8'd0;
        run_case(3'b000, 3'b100, 0, 3'b000, 3'b111, 10, "R11 zero settle ground W");
        settle = 8'd7;
        run_case(3'b010, 3'b000, 0, 3'b111, 3'b000, 6,  "R11 long settle battery V");
        chk(fault[22:19] == 0, "R12 reserved bits zero", 32'(fault[22:19]), 0);

        step(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired act=%0d exp=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule